// File: doc/BRIEF.md
# Segmented Dispatch Entry Allocator

This block assigns free scheduler entries to instructions that arrive through several dispatch slots in the same cycle. The scheduler's entries are split into equal segments. Each dispatch slot is wired to exactly one segment, and each segment has its own small picker. A picker can hand out at most one entry per cycle.

The block holds one availability bit per entry. A slot that requests an entry gets the lowest-numbered free entry of its own segment, together with a grant. If that segment has no free entry, the slot stalls, even when other segments still have room. Entries are returned through a release mask. Allocations take effect on the clock edge after the grant, and releases take effect on that same edge.

Top module: `rsa_seg_alloc`

## Requirements
- R1: After reset every entry is free, so `avail_vec` reads all ones. A 1 in `avail_vec` means the entry is free.
- R2: Slot k is granted exactly when `disp_req[k]` is high and segment k has a free entry. Segment k holds entries k*SEG_SIZE to k*SEG_SIZE+SEG_SIZE-1. The slot's index field is bits [k*IDXW +: IDXW] of `entry_idx`. That field names an entry inside segment k and reads 0 whenever the grant is low.
- R3: Within a segment, the granted entry is the free entry with the lowest index.
- R4: A slot whose segment has no free entry gets no grant, even when other segments have free entries.
- R5: An entry granted in a cycle reads as busy (0 in `avail_vec`) after the next rising clock edge.
- R6: Every entry set in `release_mask` reads as free after the next rising clock edge.
- R7: An entry is never granted while it is busy, so no entry is allocated twice. A release and an allocation never target the same entry in the same cycle.
- R8: A segment grants at most one entry per cycle, and the entries granted to different slots in one cycle are all distinct.
- R9: In a cycle with no request and an all-zero release mask, `avail_vec` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_req | input | NUM_SEG | Per-slot request for an entry |
| release_mask | input | NUM_SEG*SEG_SIZE | Entries returned at the next edge |
| grant | output | NUM_SEG | Per-slot grant |
| entry_idx | output | NUM_SEG*IDXW | Per-slot granted entry index |
| avail_vec | output | NUM_SEG*SEG_SIZE | Current availability, 1 = free |

## Verification
The bench uses the default configuration: four segments of four entries each, sixteen entries in total. It sweeps every one of the sixteen free patterns a segment can hold, and gives each segment a different pattern in the same cycle. It then drains every pattern one grant per cycle. This covers every lowest-free choice and every case where one segment is full while its neighbours are not. A long pseudo-random phase follows, mixing requests, releases and idle cycles. The bench checks that phase against an arithmetic model of the availability vector, which also catches any double allocation.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
    localparam int RSA_NUM_SEG_DEF  = 4;
    localparam int RSA_SEG_SIZE_DEF = 4;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rsa_seg_pick.sv
module rsa_seg_pick #(
    parameter int WAYS = 4,
    localparam int LW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] free_vec,
    output logic            any_free,
    output logic [LW-1:0]   pick_idx,
    output logic [WAYS-1:0] pick_oh
);
    // lowest free way wins: scan downward so the last hit is the lowest
    always_comb begin
        any_free = 1'b0;
        pick_idx = '0;
        pick_oh  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free   = 1'b1;
                pick_idx   = LW'(i);
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (!$isunknown(free_vec)) begin
            AST_PICK_ONEHOT: assert ($onehot0(pick_oh)); // R8
            AST_PICK_IS_FREE: assert ((pick_oh & ~free_vec) == '0); // R7
        end
    end
endmodule

// File: rtl/rsa_avail_reg.sv
module rsa_avail_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_mask,
    input  logic [N-1:0] release_mask,
    output logic [N-1:0] avail_q
);
    typedef struct packed {
        logic [N-1:0] avail;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.avail = (st_q.avail & ~alloc_mask) | release_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{avail: '1};
        else        st_q <= st_d;
    end

    assign avail_q = st_q.avail;

    AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_mask != '0) |=> ((avail_q & $past(alloc_mask)) == '0)); // R5
    AST_RELEASE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask != '0) |=> ((avail_q & $past(release_mask)) == $past(release_mask))); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_mask & release_mask) == '0)); // R7
    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_mask & ~avail_q) == '0)); // R7
endmodule

// File: rtl/rsa_seg_alloc.sv
module rsa_seg_alloc #(
    parameter int NUM_SEG  = rsa_pkg::RSA_NUM_SEG_DEF,
    parameter int SEG_SIZE = rsa_pkg::RSA_SEG_SIZE_DEF,
    localparam int N    = NUM_SEG * SEG_SIZE,
    localparam int IDXW = rsa_pkg::idx_bits(N),
    localparam int LW   = rsa_pkg::idx_bits(SEG_SIZE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SEG-1:0]      disp_req,
    input  logic [N-1:0]            release_mask,
    output logic [NUM_SEG-1:0]      grant,
    output logic [NUM_SEG*IDXW-1:0] entry_idx,
    output logic [N-1:0]            avail_vec
);
    logic [N-1:0]       avail_q;
    logic [N-1:0]       alloc_d;
    logic [NUM_SEG-1:0] seg_has_free;

    rsa_avail_reg #(.N(N)) u_avail (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_mask   (alloc_d),
        .release_mask (release_mask),
        .avail_q      (avail_q)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic [LW-1:0]       loc_idx;
        logic [SEG_SIZE-1:0] loc_oh;

        rsa_seg_pick #(.WAYS(SEG_SIZE)) u_pick (
            .free_vec (avail_q[g*SEG_SIZE +: SEG_SIZE]),
            .any_free (seg_has_free[g]),
            .pick_idx (loc_idx),
            .pick_oh  (loc_oh)
        );

        always_comb begin
            grant[g] = disp_req[g] & seg_has_free[g];
            alloc_d[g*SEG_SIZE +: SEG_SIZE] = grant[g] ? loc_oh : '0;
            entry_idx[g*IDXW +: IDXW] = grant[g] ? IDXW'(g * SEG_SIZE + int'(loc_idx)) : '0;
        end
    end

    assign avail_vec = avail_q;

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~disp_req) == '0)); // R2
    AST_ONE_PER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(alloc_d) == $countones(grant))); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_req == '0) && (release_mask == '0)) |=> $stable(avail_vec)); // R9
endmodule

// File: tb/tb_rsa_seg_alloc.sv
module tb_rsa_seg_alloc;
    localparam int NS = 4;
    localparam int SS = 4;
    localparam int N  = NS * SS;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    disp_req = '0;
    logic [N-1:0]     release_mask = '0;
    logic [NS-1:0]    grant;
    logic [NS*IW-1:0] entry_idx;
    logic [N-1:0]     avail_vec;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] model;
    logic [31:0]  rng = 32'h1234_5678;
    string        avail_tag = "R1";
    bit           done = 1'b0;

    always #5 clk = ~clk;

    rsa_seg_alloc dut (
        .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .release_mask(release_mask),
        .grant(grant), .entry_idx(entry_idx), .avail_vec(avail_vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // drive at negedge, check combinational outputs, model the next edge
    task automatic step(input logic [NS-1:0] req, input logic [N-1:0] rel);
        logic [N-1:0] alloc = '0;
        @(negedge clk);
        chk(avail_vec == model, avail_tag, int'(avail_vec), int'(model));
        disp_req = req;
        release_mask = rel;
        #1;
        for (int k = 0; k < NS; k++) begin
            logic [SS-1:0] seg = model[k*SS +: SS];
            bit eg = req[k] && (seg != '0);
            int lo = 0;
            int got;
            for (int w = SS - 1; w >= 0; w--) if (seg[w]) lo = w;
            chk(grant[k] == eg, (req[k] && seg == '0) ? "R4" : "R2", int'(grant[k]), int'(eg));
            got = int'(entry_idx[k*IW +: IW]);
            if (eg) begin
                chk(got == k*SS + lo, "R3", got, k*SS + lo);
                chk(model[got] == 1'b1 && alloc[got] == 1'b0, "R7", got, k*SS + lo);
                alloc[got] = 1'b1;
            end else begin
                chk(got == 0, "R2", got, 0);
            end
        end
        chk($countones(alloc) == $countones(grant), "R8", $countones(grant), $countones(alloc));
        model = (model & ~alloc) | rel;
        if (rel != '0)          avail_tag = "R6";
        else if (req == '0)     avail_tag = "R9";
        else                    avail_tag = "R5";
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired after %0d cycles", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        model = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        avail_tag = "R1";
        // fill all segments, fifth round sees every segment full (R4)
        for (int i = 0; i < SS + 1; i++) step('1, '0);
        // exhaustive sweep of segment free patterns, each segment differs
        for (int p = 0; p < 16; p++) begin
            logic [N-1:0] rel = '0;
            for (int k = 0; k < NS; k++) rel[k*SS +: SS] = SS'((p + 5*k) % 16);
            step('0, rel);
            for (int i = 0; i < SS + 1; i++) step('1, '0);
            step(4'b0101, '0);
        end
        // pseudo-random mix of requests, releases and idle cycles
        for (int t = 0; t < 3000; t++) begin
            logic [NS-1:0] req;
            logic [N-1:0]  rel;
            rng = nxt(rng);
            req = rng[3:0];
            rel = rng[31:16] & rng[15:0] & ~model;
            if (rng[7:5] == 3'd0) begin
                req = '0;
                rel = '0;
            end
            step(req, rel);
        end
        step('0, '0);
        step('0, '0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule